// File: doc/BRIEF.md
# Chunked Object-to-Tile Binner

This block sorts scene objects into screen tiles, one chunk at a time. A chunk holds `N` object bounding boxes and covers a strip of `N` tiles. The tiles lie side by side in one tile row, and the first tile sits at a given tile column. All `N` boxes enter in a single handshake. Every object slot tests its own box against the whole strip in parallel. It does this by building a run of ones from the box's first and last tile column, not by comparing against each tile in turn. The result is an `N`-bit hit mask per object. The `N` by `N` bit matrix is then transposed, so that each tile holds a mask of the objects that touch it.

The block then drains the chunk. In every emit cycle, each tile that still has set bits offers the index of its lowest remaining object on its own output lane. When that lane's handshake completes, the tile clears that bit. Objects therefore leave each tile in ascending slot order. When every lane is always ready, a chunk takes as many emit cycles as the largest number of objects hitting any one tile. A chunk that touches no tile takes no emit cycles, and the next chunk can be accepted on the following clock.

The controller has two states. `ST_IDLE` accepts a chunk. `ST_EMIT` drains it. The transition `load_hits` goes from `ST_IDLE` to `ST_EMIT` when an accepted chunk has any hit. The transition `load_empty` stays in `ST_IDLE` when an accepted chunk has no hit. The transition `drain_done` returns from `ST_EMIT` to `ST_IDLE` once every tile mask has emptied after the current cycle's handshakes. Otherwise `ST_EMIT` holds.

Top module: `tile_binner`

## Requirements
- R1: After reset, `in_ready` is 1 and every bit of `out_valid` is 0.
- R2: Object slot j takes its box from bits `[j*CW +: CW]` of `in_x0`, `in_x1`, `in_y0` and `in_y1`, given in pixels. Tiles are 16 by 16 pixels. Tile t of the strip has tile column `in_col_base + t` and tile row `in_row`. Object j hits tile t exactly when `x0>>4 <= in_col_base+t <= x1>>4` and `y0>>4 <= in_row <= y1>>4`.
- R3: Over one chunk, lane t (index on `out_idx[t*IW +: IW]`) delivers through completed handshakes exactly the slot indices of the objects that hit tile t, each once, in strictly ascending order.
- R4: With `out_ready` held all ones, a chunk that has hits keeps `in_ready` low for exactly as many cycles as the largest per-tile hit count.
- R5: A chunk with no hits leaves `in_ready` high on the next cycle, drives no valid, and lets the following chunk be accepted there.
- R6: A lane whose valid is high and whose ready is low keeps its valid high and its index unchanged on the next cycle.
- R7: While `in_ready` is high, no lane is valid. When `in_ready` falls, at least one lane is valid in that cycle.
- R8: After a handshake on a lane, any index that lane shows on the next cycle is larger than the one just delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A chunk of boxes is offered |
| in_ready | output | 1 | Block can take a chunk (idle) |
| in_row | input | CW-4 | Tile row of the strip |
| in_col_base | input | CW-4 | Tile column of strip tile 0 |
| in_x0 | input | N*CW | Left pixel edge per object slot |
| in_x1 | input | N*CW | Right pixel edge per object slot |
| in_y0 | input | N*CW | Top pixel edge per object slot |
| in_y1 | input | N*CW | Bottom pixel edge per object slot |
| out_valid | output | N | Per-tile lane has an object index |
| out_ready | input | N | Per-tile lane consumer accepts |
| out_idx | output | N*log2(N) | Per-tile object slot index |

## Verification
The assertions check four things on every cycle. A stalled lane must hold its valid and its index (R6). No lane may be valid while the block is idle. A drain must start with at least one valid lane (R7). The index on a lane must rise after each delivery (R8). Only the bench scenarios can show the rest. These are the geometric hit rule, including boxes clamped at either end of the strip, boxes outside the strip and boxes on another row (R2). They also cover the completeness of each tile's list (R3), the exact drain length against the largest popcount (R4), and the immediate reload after an empty chunk (R5).

// File: rtl/tile_binner_pkg.sv
package tile_binner_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } bin_state_t;

endpackage

// File: rtl/tile_binner_objmask.sv
module tile_binner_objmask #(
    parameter int N   = 32,
    parameter int CW  = 12,
    parameter int TSH = 4
) (
    input  logic [CW-1:0]     x0,
    input  logic [CW-1:0]     x1,
    input  logic [CW-1:0]     y0,
    input  logic [CW-1:0]     y1,
    input  logic [CW-TSH-1:0] row,
    input  logic [CW-TSH-1:0] base,
    output logic [N-1:0]      hits
);
    localparam int TW = CW - TSH;
    localparam int SW = TW + 2;
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic signed [SW-1:0] LAST = SW'(N - 1);
    localparam logic [N-1:0] ONES = '1;

    logic signed [SW-1:0] lo, hi;
    logic [IW-1:0] lo_c, hi_c;
    logic          x_in, y_in;

    always_comb begin
        lo   = $signed({2'b00, x0[CW-1:TSH]}) - $signed({2'b00, base});
        hi   = $signed({2'b00, x1[CW-1:TSH]}) - $signed({2'b00, base});
        y_in = (y0[CW-1:TSH] <= row) && (row <= y1[CW-1:TSH]);
        x_in = (hi >= 0) && (lo <= LAST) && (lo <= hi);
        lo_c = (lo < 0) ? '0 : lo[IW-1:0];
        hi_c = (hi > LAST) ? IW'(N - 1) : hi[IW-1:0];
        if (x_in && y_in)
            hits = (ONES << lo_c) & (ONES >> (IW'(N - 1) - hi_c));
        else
            hits = '0;
    end
endmodule

// File: rtl/tile_binner_transpose.sv
module tile_binner_transpose #(
    parameter int N = 32
) (
    input  logic [N*N-1:0] obj_m,
    output logic [N*N-1:0] tile_m
);
    for (genvar t = 0; t < N; t++) begin : g_tile
        for (genvar j = 0; j < N; j++) begin : g_obj
            assign tile_m[t*N + j] = obj_m[j*N + t];
        end
    end
endmodule

// File: rtl/tile_binner_pick.sv
module tile_binner_pick #(
    parameter int N = 32
) (
    input  logic [N-1:0]                         mask,
    output logic                                 any,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx,
    output logic [N-1:0]                         rest
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (mask[k]) idx = IW'(k);
        end
        any  = |mask;
        rest = mask & (mask - N'(1));
    end
endmodule

// File: rtl/tile_binner.sv
module tile_binner
    import tile_binner_pkg::*;
#(
    parameter int N   = 32,
    parameter int CW  = 12,
    parameter int TSH = 4,
    localparam int TW = CW - TSH,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [TW-1:0]   in_row,
    input  logic [TW-1:0]   in_col_base,
    input  logic [N*CW-1:0] in_x0,
    input  logic [N*CW-1:0] in_x1,
    input  logic [N*CW-1:0] in_y0,
    input  logic [N*CW-1:0] in_y1,
    output logic [N-1:0]    out_valid,
    input  logic [N-1:0]    out_ready,
    output logic [N*IW-1:0] out_idx
);
    bin_state_t     state_q, state_d;
    logic [N*N-1:0] obj_m, tile_m, mask_q, mask_d, rest_m;
    logic [N-1:0]   any_m;

    for (genvar j = 0; j < N; j++) begin : g_obj
        tile_binner_objmask #(.N(N), .CW(CW), .TSH(TSH)) u_objmask (
            .x0   (in_x0[j*CW +: CW]),
            .x1   (in_x1[j*CW +: CW]),
            .y0   (in_y0[j*CW +: CW]),
            .y1   (in_y1[j*CW +: CW]),
            .row  (in_row),
            .base (in_col_base),
            .hits (obj_m[j*N +: N])
        );
    end

    tile_binner_transpose #(.N(N)) u_xpose (
        .obj_m  (obj_m),
        .tile_m (tile_m)
    );

    for (genvar t = 0; t < N; t++) begin : g_tile
        tile_binner_pick #(.N(N)) u_pick (
            .mask (mask_q[t*N +: N]),
            .any  (any_m[t]),
            .idx  (out_idx[t*IW +: IW]),
            .rest (rest_m[t*N +: N])
        );
    end

    // State register and tile masks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    // Next state, next masks and outputs
    always_comb begin
        state_d   = state_q;
        mask_d    = mask_q;
        in_ready  = 1'b0;
        out_valid = '0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    mask_d  = tile_m;
                    state_d = (|tile_m) ? ST_EMIT : ST_IDLE;
                end
            end
            ST_EMIT: begin
                out_valid = any_m;
                for (int t = 0; t < N; t++) begin
                    if (any_m[t] && out_ready[t])
                        mask_d[t*N +: N] = rest_m[t*N +: N];
                end
                if (mask_d == '0) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (out_valid == '0));

    // R7
    drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> (out_valid != '0));

    for (genvar t = 0; t < N; t++) begin : g_chk
        // R6
        stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[t] && !out_ready[t]) |=>
                (out_valid[t] && $stable(out_idx[t*IW +: IW])));

        // R8
        rising_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[t] && out_ready[t]) |=>
                (!out_valid[t] || (out_idx[t*IW +: IW] > $past(out_idx[t*IW +: IW]))));
    end
endmodule

// File: tb/tile_binner_tb.sv
module tile_binner_tb;
    localparam int N  = 32;
    localparam int CW = 12;
    localparam int TW = CW - 4;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [TW-1:0]   in_row = '0;
    logic [TW-1:0]   in_col_base = '0;
    logic [N*CW-1:0] in_x0 = '0, in_x1 = '0, in_y0 = '0, in_y1 = '0;
    logic [N-1:0]    out_valid;
    logic [N-1:0]    out_ready = '0;
    logic [N*IW-1:0] out_idx;

    int checks = 0;
    int errors = 0;
    int expl [N][N];
    int expn [N];
    int gotl [N][N];
    int gotn [N];

    always #5 clk = ~clk;

    tile_binner #(.N(N), .CW(CW), .TSH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_row(in_row), .in_col_base(in_col_base),
        .in_x0(in_x0), .in_x1(in_x1), .in_y0(in_y0), .in_y1(in_y1),
        .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit hit(input int j, input int t);
        int col;
        col = int'(in_col_base) + t;
        return (int'(in_x0[j*CW +: CW]) >> 4) <= col && col <= (int'(in_x1[j*CW +: CW]) >> 4) &&
               (int'(in_y0[j*CW +: CW]) >> 4) <= int'(in_row) &&
               int'(in_row) <= (int'(in_y1[j*CW +: CW]) >> 4);
    endfunction

    function automatic void set_box(input int j, input int x0, input int x1, input int y0, input int y1);
        in_x0[j*CW +: CW] = CW'(x0);
        in_x1[j*CW +: CW] = CW'(x1);
        in_y0[j*CW +: CW] = CW'(y0);
        in_y1[j*CW +: CW] = CW'(y1);
    endfunction

    // Runs one chunk; stall_pct is the chance a lane is not ready.
    task automatic run_chunk(input int stall_pct);
        int maxp = 0, cyc = 0;
        bit stalled [N];
        int pidx [N];
        for (int t = 0; t < N; t++) begin
            expn[t] = 0; gotn[t] = 0; stalled[t] = 0; pidx[t] = 0;
            for (int j = 0; j < N; j++)
                if (hit(j, t)) begin expl[t][expn[t]] = j; expn[t]++; end
            if (expn[t] > maxp) maxp = expn[t];
        end
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (maxp == 0) begin
            check(in_ready == 1'b1, "R5 ready after empty chunk", int'(in_ready), 1);
            check(out_valid == '0, "R5 no valid after empty chunk", int'(out_valid != '0), 0);
        end
        while (!in_ready && cyc < 200) begin
            for (int t = 0; t < N; t++)
                out_ready[t] = ($urandom % 100) >= stall_pct;
            #1;
            for (int t = 0; t < N; t++) begin
                if (stalled[t])
                    check(out_valid[t] && int'(out_idx[t*IW +: IW]) == pidx[t],
                          "R6 stalled lane holds", int'(out_idx[t*IW +: IW]), pidx[t]);
                stalled[t] = out_valid[t] && !out_ready[t];
                pidx[t] = int'(out_idx[t*IW +: IW]);
                if (out_valid[t] && out_ready[t] && gotn[t] < N) begin
                    gotl[t][gotn[t]] = int'(out_idx[t*IW +: IW]);
                    gotn[t]++;
                end
            end
            cyc++;
            @(negedge clk);
        end
        out_ready = '0;
        for (int t = 0; t < N; t++) begin
            check(gotn[t] == expn[t], "R3 tile list length", gotn[t], expn[t]);
            for (int k = 0; k < expn[t] && k < gotn[t]; k++)
                check(gotl[t][k] == expl[t][k], "R2 R3 tile list entry", gotl[t][k], expl[t][k]);
        end
        if (stall_pct == 0)
            check(cyc == maxp, "R4 emit cycles equal max popcount", cyc, maxp);
    endtask

    initial begin
        void'($urandom(32'd2718));
        #1;
        check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        check(out_valid == '0, "R1 reset out_valid", int'(out_valid != '0), 0);
        #20 rst_n = 1'b1;
        @(negedge clk);

        // Directed: clamping at both strip ends, off-row and outside boxes
        in_row = 8'd3; in_col_base = 8'd10;
        for (int j = 0; j < N; j++) set_box(j, 0, 0, 0, 0);
        set_box(0, 0, 4095, 48, 63);
        set_box(1, 160, 175, 40, 50);
        set_box(2, 656, 700, 48, 48);
        set_box(3, 100, 200, 64, 80);
        set_box(4, 700, 900, 48, 60);
        set_box(5, 300, 200, 48, 60);
        set_box(31, 170, 330, 0, 100);
        run_chunk(0);

        // Directed: empty chunk, then immediate reload (R5)
        for (int j = 0; j < N; j++) set_box(j, 0, 15, 0, 15);
        in_row = 8'd9;
        run_chunk(0);
        in_row = 8'd0; in_col_base = 8'd0;
        run_chunk(0);

        // Directed: every object covers every tile
        for (int j = 0; j < N; j++) set_box(j, 0, 4095, 0, 4095);
        run_chunk(0);

        // Random chunks, with and without lane stalls
        for (int c = 0; c < 40; c++) begin
            in_row = TW'($urandom % 16);
            in_col_base = TW'($urandom % 64);
            for (int j = 0; j < N; j++) begin
                int xa, w, ya, h;
                xa = $urandom % 1600; w = $urandom % 400;
                ya = $urandom % 256;  h = $urandom % 96;
                set_box(j, xa, (xa + w > 4095) ? 4095 : xa + w, ya, ya + h);
            end
            run_chunk((c % 2 == 0) ? 0 : 40);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule